// File: doc/BRIEF.md
# Conversion Queue Single-Scan Sequencer

This block runs one queue of conversion command words through an analog-to-digital converter exactly once per arming. Software selects a queue operating mode and sets an arming bit. The scan then starts on a trigger: immediately in software mode, on a rising edge of an external trigger pin, or on an interval-timer expiry. The block walks the command-word addresses from zero and requests a conversion for each word. It waits for the converter's done pulse before moving on. Each word carries two flags. A pause flag halts the scan until a fresh trigger arrives. An end flag finishes the queue.

On completion the arming bit clears itself, the status returns to idle, and a sticky completion flag is raised. That flag can drive an interrupt. A trigger that arrives while a conversion is running in external or timer mode sets a sticky overrun flag. Changing the operating mode in the middle of a scan aborts the running conversion. The new mode and the arming value written with it then apply at once. The converter sits outside the block and is reached through a request/done/abort port.

Top module: `scanq_single_seq`

## Requirements
- R1: While the queue is not armed, external edges and timer expiries are ignored: status stays idle (`q_status`=00) and `conv_start` stays low.
- R2: `arm_rdata`, the read value of the arming bit, is always 0.
- R3: Mode encoding is 00 off, 01 software, 10 external, 11 timer. In software mode, a control write with `ctl_arm`=1 makes the status active (01) with `conv_start` high at `cw_addr` 0 on the next cycle.
- R4: A control write that keeps the same mode, with `ctl_arm` set to either value, has no effect on a scan that is armed or running. The address and status are unchanged.
- R5: A done pulse for a word with `cw_end` set (or for the word at address DEPTH-1) returns the status to idle, drops `conv_start`, sets `cw_addr` to 0 and sets `done_flag`. A later arming write restarts the scan at address 0.
- R6: In external or timer mode, arming gives status trigger-pending (11) with `conv_start` low. The scan starts at address 0 only on a trigger. The external pin passes through a two-flop synchroniser, and each rising edge yields one trigger.
- R7: A done pulse for a word with `cw_pause` set gives status paused (10) with `conv_start` low. In software mode the scan resumes at the next address after exactly two paused cycles. In external or timer mode it resumes only on the next trigger.
- R8: A trigger arriving while a conversion is running in external or timer mode sets `ovr_flag`.
- R9: A control write with a different mode during a running conversion pulses `conv_abort` for one cycle. The address resets to 0, and the status follows the new mode and the written arming value (software+arm: active; external or timer+arm: pending; otherwise idle).
- R10: `clr_done` clears `done_flag`. When completion and `clr_done` fall in the same cycle, the flag ends up set.
- R11: `done_irq` equals `done_flag` ANDed with the interrupt-enable bit taken from the last control write.
- R12: `clr_ovr` clears `ovr_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_mode | input | 2 | Written queue operating mode |
| ctl_arm | input | 1 | Written arming bit |
| ctl_ie | input | 1 | Written completion interrupt enable |
| clr_done | input | 1 | Write-one-to-clear for the completion flag |
| clr_ovr | input | 1 | Write-one-to-clear for the overrun flag |
| arm_rdata | output | 1 | Read value of the arming bit (always 0) |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| tmr_expire | input | 1 | Interval timer expiry pulse |
| cw_addr | output | $clog2(DEPTH) | Address of the current command word |
| cw_pause | input | 1 | Pause flag of the word at `cw_addr` |
| cw_end | input | 1 | End-of-queue flag of the word at `cw_addr` |
| conv_start | output | 1 | Conversion request, held until done |
| conv_done | input | 1 | Conversion complete pulse |
| conv_abort | output | 1 | One-cycle pulse cancelling the running conversion |
| done_flag | output | 1 | Sticky queue completion flag |
| done_irq | output | 1 | Completion interrupt |
| ovr_flag | output | 1 | Sticky trigger overrun flag |
| q_status | output | 2 | Queue status: 00 idle, 01 active, 10 paused, 11 pending |

## Verification
Two pairs of events can land in the same cycle. The first pair is queue completion and the software clear of the completion flag. The bench drives `conv_done` on the final word together with `clr_done` and expects the flag to read set afterwards. The second pair is a trigger and a running conversion in external or timer mode. The bench fires an edge or a timer pulse mid-conversion. It expects `ovr_flag` to be set while address and status stay unchanged, and it then checks that the write-one clear removes the flag.

// File: rtl/scanq_pkg.sv
// Shared encodings for the single-scan queue sequencer.
// Assumes: 2-bit mode and status fields as documented in the brief.
package scanq_pkg;
    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_SW  = 2'b01,
        MODE_EXT = 2'b10,
        MODE_TMR = 2'b11
    } qmode_e;

    typedef enum logic [1:0] {
        QS_IDLE    = 2'b00,
        QS_ACTIVE  = 2'b01,
        QS_PAUSED  = 2'b10,
        QS_PENDING = 2'b11
    } qstat_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RUN,
        ST_HOLD,
        ST_GAP
    } seq_e;
endpackage

// File: rtl/scanq_edge_sync.sv
// Synchronises the asynchronous trigger pin and emits a one-cycle pulse
// per rising edge. Assumes SYNC_STAGES >= 2 and pin pulses wider than
// one clock.
module scanq_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sh;
    logic         last_q;

    // shift the pin through the synchroniser chain and keep the prior output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            last_q <= 1'b0;
        end else begin
            sh     <= {sh[TOP-1:0], pin};
            last_q <= sh[TOP];
        end
    end

    assign rise = sh[TOP] & ~last_q;

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/scanq_trig_sel.sv
// Chooses the trigger source for the selected mode. Software mode has no
// outside source (its triggers are generated in the sequencer).
module scanq_trig_sel
    import scanq_pkg::*;
(
    input  qmode_e mode,
    input  logic   ext_rise,
    input  logic   tmr_expire,
    output logic   trig
);
    // route the source that belongs to the current mode
    always_comb begin
        unique case (mode)
            MODE_EXT: trig = ext_rise;
            MODE_TMR: trig = tmr_expire;
            default:  trig = 1'b0;
        endcase
    end
endmodule

// File: rtl/scanq_flags.sv
// Sticky completion and overrun flags with write-one clears, plus the
// interrupt enable. Assumes set events win over clears in one cycle.
module scanq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_we,
    input  logic ctl_ie,
    input  logic done_evt,
    input  logic ovr_evt,
    input  logic clr_done,
    input  logic clr_ovr,
    output logic done_flag,
    output logic ovr_flag,
    output logic done_irq
);
    logic ie_q;

    // hold flags and the interrupt enable; set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            ovr_flag  <= 1'b0;
            ie_q      <= 1'b0;
        end else begin
            if (done_evt)      done_flag <= 1'b1;
            else if (clr_done) done_flag <= 1'b0;
            if (ovr_evt)       ovr_flag  <= 1'b1;
            else if (clr_ovr)  ovr_flag  <= 1'b0;
            if (ctl_we)        ie_q      <= ctl_ie;
        end
    end

    assign done_irq = done_flag & ie_q;

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> done_flag);
    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !clr_ovr) |=> ovr_flag);
    a_r12_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovr && !ovr_evt) |=> !ovr_flag);
endmodule

// File: rtl/scanq_seq_fsm.sv
// Queue walker: arming, trigger waits, per-word conversion handshake,
// pauses, end of queue and mode-change abort. Assumes conv_done only
// arrives while conv_start is high, and that cw_pause/cw_end describe the
// word at cw_addr.
module scanq_seq_fsm
    import scanq_pkg::*;
#(
    parameter  int DEPTH      = 16,
    parameter  int GAP_CYCLES = 2,
    localparam int AW         = $clog2(DEPTH),
    localparam int GW         = $clog2(GAP_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  qmode_e        ctl_mode,
    input  logic          ctl_arm,
    input  logic          trig,
    input  logic          conv_done,
    input  logic          cw_pause,
    input  logic          cw_end,
    output logic [AW-1:0] cw_addr,
    output logic          conv_start,
    output logic          conv_abort,
    output qstat_e        q_status,
    output qmode_e        mode,
    output logic          done_evt,
    output logic          ovr_evt
);
    seq_e          st;
    logic [GW-1:0] gap;
    logic          mode_chg;
    logic          last_word;

    assign mode_chg  = ctl_we && (ctl_mode != mode);
    assign last_word = cw_end || (cw_addr == AW'(DEPTH - 1));

    // completion and overrun events for the flag block
    assign done_evt = (st == ST_RUN) && conv_done && last_word && !mode_chg;
    assign ovr_evt  = (st == ST_RUN) && trig && !mode_chg;

    // sequencing state, address and abort pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            mode       <= MODE_OFF;
            cw_addr    <= '0;
            gap        <= '0;
            conv_abort <= 1'b0;
        end else begin
            conv_abort <= 1'b0;
            if (mode_chg) begin
                mode       <= ctl_mode;
                cw_addr    <= '0;
                gap        <= '0;
                conv_abort <= (st == ST_RUN);
                if (ctl_arm && ctl_mode == MODE_SW)       st <= ST_RUN;
                else if (ctl_arm && ctl_mode != MODE_OFF) st <= ST_WAIT;
                else                                      st <= ST_IDLE;
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        if (ctl_we && ctl_arm && mode != MODE_OFF) begin
                            cw_addr <= '0;
                            st      <= (mode == MODE_SW) ? ST_RUN : ST_WAIT;
                        end
                    end
                    ST_WAIT: if (trig) st <= ST_RUN;
                    ST_RUN: begin
                        if (conv_done) begin
                            if (last_word) begin
                                cw_addr <= '0;
                                st      <= ST_IDLE;
                            end else begin
                                cw_addr <= cw_addr + 1'b1;
                                if (cw_pause) begin
                                    gap <= '0;
                                    st  <= (mode == MODE_SW) ? ST_GAP : ST_HOLD;
                                end
                            end
                        end
                    end
                    ST_HOLD: if (trig) st <= ST_RUN;
                    ST_GAP: begin
                        if (gap == GW'(GAP_CYCLES - 1)) st  <= ST_RUN;
                        else                            gap <= gap + 1'b1;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // map internal state to the reported status and converter request
    always_comb begin
        unique case (st)
            ST_RUN:          q_status = QS_ACTIVE;
            ST_HOLD, ST_GAP: q_status = QS_PAUSED;
            ST_WAIT:         q_status = QS_PENDING;
            default:         q_status = QS_IDLE;
        endcase
    end

    assign conv_start = (st == ST_RUN);

    a_r1_unarmed_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q_status == QS_IDLE && !ctl_we) |=> q_status == QS_IDLE);
    a_r3_sw_arm_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (q_status == QS_IDLE && ctl_we && ctl_arm && ctl_mode == MODE_SW)
        |=> (conv_start && cw_addr == '0));
    a_r5_end_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> (q_status == QS_IDLE && !conv_start));
    a_r7_paused_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        (q_status == QS_PAUSED) |-> !conv_start);
    a_r9_abort_on_mode_change: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && conv_start) |=> (conv_abort && cw_addr == '0));
    a_r4_same_mode_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (q_status == QS_PENDING && ctl_we && !mode_chg && !trig)
        |=> q_status == QS_PENDING);
endmodule

// File: rtl/scanq_single_seq.sv
// Top of the single-scan queue sequencer: trigger synchroniser, source
// select, queue walker and sticky flags. Assumes one command-word lookup
// outside the block, combinational on cw_addr.
module scanq_single_seq
    import scanq_pkg::*;
#(
    parameter  int DEPTH       = 16,
    parameter  int SYNC_STAGES = 2,
    parameter  int GAP_CYCLES  = 2,
    localparam int AW          = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic [1:0]    ctl_mode,
    input  logic          ctl_arm,
    input  logic          ctl_ie,
    input  logic          clr_done,
    input  logic          clr_ovr,
    output logic          arm_rdata,
    input  logic          ext_trig,
    input  logic          tmr_expire,
    output logic [AW-1:0] cw_addr,
    input  logic          cw_pause,
    input  logic          cw_end,
    output logic          conv_start,
    input  logic          conv_done,
    output logic          conv_abort,
    output logic          done_flag,
    output logic          done_irq,
    output logic          ovr_flag,
    output logic [1:0]    q_status
);
    logic   ext_rise;
    logic   trig;
    logic   done_evt;
    logic   ovr_evt;
    qmode_e mode;
    qstat_e stat;

    assign arm_rdata = 1'b0;
    assign q_status  = stat;

    scanq_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_trig),
        .rise  (ext_rise)
    );

    scanq_trig_sel u_sel (
        .mode       (mode),
        .ext_rise   (ext_rise),
        .tmr_expire (tmr_expire),
        .trig       (trig)
    );

    scanq_seq_fsm #(.DEPTH(DEPTH), .GAP_CYCLES(GAP_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_mode   (qmode_e'(ctl_mode)),
        .ctl_arm    (ctl_arm),
        .trig       (trig),
        .conv_done  (conv_done),
        .cw_pause   (cw_pause),
        .cw_end     (cw_end),
        .cw_addr    (cw_addr),
        .conv_start (conv_start),
        .conv_abort (conv_abort),
        .q_status   (stat),
        .mode       (mode),
        .done_evt   (done_evt),
        .ovr_evt    (ovr_evt)
    );

    scanq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_ie    (ctl_ie),
        .done_evt  (done_evt),
        .ovr_evt   (ovr_evt),
        .clr_done  (clr_done),
        .clr_ovr   (clr_ovr),
        .done_flag (done_flag),
        .ovr_flag  (ovr_flag),
        .done_irq  (done_irq)
    );
endmodule

// File: tb/scanq_single_seq_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module scanq_single_seq_test;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_we = 1'b0, ctl_arm = 1'b0, ctl_ie = 1'b0;
    logic [1:0] ctl_mode = 2'b00;
    logic clr_done = 1'b0, clr_ovr = 1'b0;
    logic ext_trig = 1'b0, tmr_expire = 1'b0, conv_done = 1'b0;
    logic arm_rdata, conv_start, conv_abort, done_flag, done_irq, ovr_flag;
    logic [1:0] q_status;
    logic [AW-1:0] cw_addr;
    logic [DEPTH-1:0] pause_map = '0;
    logic [DEPTH-1:0] end_map = '0;
    logic cw_pause, cw_end;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    assign cw_pause = pause_map[cw_addr];
    assign cw_end   = end_map[cw_addr];

    always #2.5 clk = ~clk;

    scanq_single_seq #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_mode(ctl_mode),
        .ctl_arm(ctl_arm), .ctl_ie(ctl_ie), .clr_done(clr_done),
        .clr_ovr(clr_ovr), .arm_rdata(arm_rdata), .ext_trig(ext_trig),
        .tmr_expire(tmr_expire), .cw_addr(cw_addr), .cw_pause(cw_pause),
        .cw_end(cw_end), .conv_start(conv_start), .conv_done(conv_done),
        .conv_abort(conv_abort), .done_flag(done_flag), .done_irq(done_irq),
        .ovr_flag(ovr_flag), .q_status(q_status)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [1:0] m, input logic a, input logic ie);
        ctl_we = 1'b1; ctl_mode = m; ctl_arm = a; ctl_ie = ie;
        tick();
        ctl_we = 1'b0;
    endtask

    task automatic done_pulse();
        conv_done = 1'b1;
        tick();
        conv_done = 1'b0;
    endtask

    task automatic ext_edge();
        ext_trig = 1'b1;
        repeat (4) tick();
        ext_trig = 1'b0;
        repeat (2) tick();
    endtask

    task automatic tmr_pulse();
        tmr_expire = 1'b1;
        tick();
        tmr_expire = 1'b0;
    endtask

    task automatic t_reset();
        chk(q_status == 2'b00 && !conv_start && cw_addr == 0, "R1 reset idle", q_status, 0);
        chk(!done_flag && !ovr_flag && !done_irq && !conv_abort, "R10 reset flags",
            {done_flag, ovr_flag, done_irq}, 0);
    endtask

    task automatic t_unarmed();
        wr_ctl(2'b10, 1'b0, 1'b0);
        ext_edge();
        chk(q_status == 2'b00 && !conv_start, "R1 ext ignored unarmed", q_status, 0);
        wr_ctl(2'b11, 1'b0, 1'b0);
        tmr_pulse();
        tick();
        chk(q_status == 2'b00 && !conv_start, "R1 timer ignored unarmed", q_status, 0);
    endtask

    task automatic t_sw_scan();
        pause_map = '0; end_map = 16'h0004;
        wr_ctl(2'b01, 1'b1, 1'b1);
        chk(q_status == 2'b01 && conv_start && cw_addr == 0, "R3 sw arm starts", q_status, 1);
        chk(arm_rdata == 1'b0, "R2 arm reads zero", arm_rdata, 0);
        done_pulse();
        chk(cw_addr == 1 && conv_start, "R3 next word", cw_addr, 1);
        wr_ctl(2'b01, 1'b0, 1'b1);
        chk(q_status == 2'b01 && cw_addr == 1, "R4 arm=0 ignored", cw_addr, 1);
        wr_ctl(2'b01, 1'b1, 1'b1);
        chk(q_status == 2'b01 && cw_addr == 1, "R4 arm=1 ignored", cw_addr, 1);
        done_pulse();
        done_pulse();
        chk(q_status == 2'b00 && !conv_start && cw_addr == 0, "R5 end idle", q_status, 0);
        chk(done_flag == 1'b1, "R5 done flag", done_flag, 1);
        chk(done_irq == 1'b1, "R11 irq enabled", done_irq, 1);
        clr_done = 1'b1; tick(); clr_done = 1'b0;
        chk(!done_flag && !done_irq, "R10 clear done", done_flag, 0);
        wr_ctl(2'b01, 1'b1, 1'b1);
        chk(q_status == 2'b01 && cw_addr == 0, "R5 restart at zero", cw_addr, 0);
    endtask

    task automatic t_mode_change_ext();
        done_pulse();
        chk(cw_addr == 1, "R9 setup addr", cw_addr, 1);
        wr_ctl(2'b10, 1'b1, 1'b1);
        chk(conv_abort && q_status == 2'b11 && cw_addr == 0 && !conv_start,
            "R9 abort to pending", q_status, 3);
        tick();
        chk(!conv_abort && q_status == 2'b11, "R6 pending waits", q_status, 3);
        ext_edge();
        chk(q_status == 2'b01 && cw_addr == 0 && conv_start, "R6 ext edge starts", q_status, 1);
        chk(!ovr_flag, "R8 no overrun yet", ovr_flag, 0);
        ext_edge();
        chk(ovr_flag && q_status == 2'b01 && cw_addr == 0, "R8 ext overrun", ovr_flag, 1);
        clr_ovr = 1'b1; tick(); clr_ovr = 1'b0;
        chk(!ovr_flag, "R12 clear overrun", ovr_flag, 0);
        pause_map = 16'h0001; end_map = 16'h0002;
        done_pulse();
        chk(q_status == 2'b10 && !conv_start && cw_addr == 1, "R7 ext paused", q_status, 2);
        repeat (6) tick();
        chk(q_status == 2'b10, "R7 ext stays paused", q_status, 2);
        ext_edge();
        chk(q_status == 2'b01 && cw_addr == 1, "R7 ext resumes", q_status, 1);
        chk(!ovr_flag, "R8 resume edge no overrun", ovr_flag, 1'b0);
        done_pulse();
        chk(q_status == 2'b00 && done_flag, "R5 ext end", q_status, 0);
    endtask

    task automatic t_sw_pause();
        clr_done = 1'b1; tick(); clr_done = 1'b0;
        pause_map = 16'h0001; end_map = 16'h0002;
        wr_ctl(2'b01, 1'b1, 1'b1);
        chk(q_status == 2'b01 && cw_addr == 0, "R9 idle mode change arms sw", q_status, 1);
        done_pulse();
        chk(q_status == 2'b10 && !conv_start, "R7 sw pause cycle 1", q_status, 2);
        tick();
        chk(q_status == 2'b10 && !conv_start, "R7 sw pause cycle 2", q_status, 2);
        tick();
        chk(q_status == 2'b01 && conv_start && cw_addr == 1, "R7 sw resume", q_status, 1);
        done_pulse();
        chk(q_status == 2'b00 && done_flag, "R5 sw end", q_status, 0);
    endtask

    task automatic t_timer();
        clr_done = 1'b1; tick(); clr_done = 1'b0;
        pause_map = 16'h0001; end_map = 16'h0002;
        wr_ctl(2'b11, 1'b1, 1'b0);
        chk(q_status == 2'b11 && !conv_start, "R6 timer pending", q_status, 3);
        tmr_pulse();
        chk(q_status == 2'b01 && cw_addr == 0, "R6 timer starts", q_status, 1);
        tmr_pulse();
        chk(ovr_flag == 1'b1, "R8 timer overrun", ovr_flag, 1);
        done_pulse();
        chk(q_status == 2'b10, "R7 timer paused", q_status, 2);
        repeat (3) tick();
        chk(q_status == 2'b10, "R7 timer holds", q_status, 2);
        tmr_pulse();
        chk(q_status == 2'b01 && cw_addr == 1, "R7 timer resumes", q_status, 1);
        conv_done = 1'b1; clr_done = 1'b1;
        tick();
        conv_done = 1'b0; clr_done = 1'b0;
        chk(done_flag == 1'b1 && q_status == 2'b00, "R10 set beats clear", done_flag, 1);
        chk(done_irq == 1'b0, "R11 irq masked", done_irq, 0);
        clr_ovr = 1'b1; tick(); clr_ovr = 1'b0;
        chk(!ovr_flag, "R12 clear timer overrun", ovr_flag, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_unarmed();
        t_sw_scan();
        t_mode_change_ext();
        t_sw_pause();
        t_timer();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule